// File: doc/BRIEF.md
# Receive Byte Queue with Word Read Port

This block sits between a serial engine and a register reader. The engine hands in one received byte per cycle. The reader pulls out 32-bit words, and each read takes up to four bytes packed little-endian. If fewer than four bytes are waiting, a read returns a partial word and removes only the bytes it delivered.

A status word reports how many bytes are held and whether the queue is empty. It also carries a data-ready flag and three fill-level flags. A level output signals that data is available, so the reader can be notified. A pop from an empty queue raises a sticky error flag. A one-cycle flush strobe drops all held bytes and clears the error. The queue holds 64 bytes. A push while it is full is discarded, so the engine must watch the full output and stall.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset the queue holds no bytes, `status_o` reads 32'h0000_0800, and `resp_ready_o`, `underrun_o` and `full_o` are all low.
- R2: `status_o[10:4]` holds the number of bytes currently held, as an unsigned 7-bit value. `status_o` bits 31:12 are always zero.
- R3: `status_o[0]` and `resp_ready_o` are high exactly when at least one byte is held.
- R4: `status_o[1]`, `status_o[2]` and `status_o[3]` are high when at least 16, 32 and 64 bytes are held, respectively.
- R5: `status_o[11]` is high exactly when no bytes are held.
- R6: While `pop_i` is high, `pop_data_o` shows the next word, with the oldest byte in bits 7:0 and each later byte one lane higher. When four or more bytes are held, the pop removes four.
- R7: When one to three bytes are held, `pop_data_o` carries them in the low lanes, the unused upper lanes read zero, and the pop removes only those bytes.
- R8: A pop while the queue is empty leaves the queue empty, shows zero on `pop_data_o`, and sets `underrun_o`. The flag stays set until a flush.
- R9: A flush (`flush_i` high for one cycle) empties the queue and clears `underrun_o`. A push or pop in the same cycle has no effect.
- R10: `full_o` is high when 64 bytes are held. A push while full is dropped, and the held bytes and their order are unchanged.
- R11: A push and a pop in the same cycle both take effect. The pop sees only the bytes held before that cycle, and the new byte queues behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Engine delivers a byte this cycle |
| push_byte_i | input | 8 | Received byte |
| full_o | output | 1 | Queue holds its maximum byte count |
| pop_i | input | 1 | Reader takes a word this cycle |
| pop_data_o | output | 32 | Word returned by the current pop |
| flush_i | input | 1 | Empty the queue and clear the error |
| status_o | output | 32 | Byte count, readiness, threshold and empty flags |
| resp_ready_o | output | 1 | Data is available |
| underrun_o | output | 1 | Sticky empty-pop error |

## Verification
The partial-word pop is the main corner case. A design that removed four bytes regardless of the count would jump the count below zero. One that did not mask the upper lanes would leak stale bytes into them, and both show up as wrong data or a wrong count. The threshold flags are checked one byte below and at each boundary, so an off-by-one comparison is caught. The full queue is pushed once more to confirm that the drop leaves the last word intact. A combined push and pop checks that the new byte neither appears in the popped word nor corrupts the count. An empty pop and a flush check that the error flag is sticky and that the flush clears it.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned STAT_W     = 32;
  localparam int unsigned CNT_LSB    = 4;
  localparam int unsigned CNT_FLD_W  = 7;
  localparam int unsigned EMPTY_BIT  = 11;
  localparam int unsigned N_THR      = 3;
  localparam int unsigned THR_LVL [N_THR] = '{16, 32, 64};
endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store
  import rx_pack_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;
  logic              push_ok;
  logic [2:0]        pop_n;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_n   = !pop_i ? 3'd0 :
                   (cnt_q >= CW'(WORD_BYTES)) ? 3'(WORD_BYTES) : 3'(cnt_q);
  assign count_o = cnt_q;

  // lanes beyond the held count read zero
  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    assign word_o[l*BYTE_W +: BYTE_W] =
      (cnt_q > CW'(l)) ? mem_q[rd_q + AW'(l)] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      rd_q  <= rd_q + AW'(pop_n);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_n);
    end
  end

  assert_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
  assert_full_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  assert_pop_partial_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && cnt_q < CW'(WORD_BYTES)) |=> cnt_q == '0);
endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen
  import rx_pack_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     count_i,
  output logic [STAT_W-1:0] status_o,
  output logic              ready_o
);
  logic [N_THR-1:0] thr;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign thr[t] = (32'(count_i) >= THR_LVL[t]);
  end

  assign ready_o = (count_i != '0);

  always_comb begin
    status_o = '0;
    status_o[0] = ready_o;
    status_o[N_THR:1] = thr;
    status_o[CNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(count_i);
    status_o[EMPTY_BIT] = (count_i == '0);
  end

  assert_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[EMPTY_BIT] != status_o[0]);
  assert_thr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] |-> (status_o[2] && status_o[1] && status_o[0]));
endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo
  import rx_pack_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_valid_i,
  input  logic [7:0]  push_byte_i,
  output logic        full_o,
  input  logic        pop_i,
  output logic [31:0] pop_data_o,
  input  logic        flush_i,
  output logic [31:0] status_o,
  output logic        resp_ready_o,
  output logic        underrun_o
);
  logic [CW-1:0] count;
  logic          und_q;

  rx_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_valid_i),
    .byte_i  (push_byte_i),
    .pop_i   (pop_i),
    .flush_i (flush_i),
    .word_o  (pop_data_o),
    .count_o (count),
    .full_o  (full_o)
  );

  rx_status_gen #(.CW(CW)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count_i  (count),
    .status_o (status_o),
    .ready_o  (resp_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        und_q <= 1'b0;
    else if (flush_i)                   und_q <= 1'b0;
    else if (pop_i && count == '0)      und_q <= 1'b1;
  end
  assign underrun_o = und_q;

  assert_underrun_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !resp_ready_o && !flush_i) |=> underrun_o);
  assert_underrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !flush_i) |=> underrun_o);
  assert_empty_pop_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !resp_ready_o) |-> pop_data_o == '0);
endmodule

// File: tb/rx_pack_fifo_tb.sv
module rx_pack_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [7:0]  push_byte = '0;
  logic        full;
  logic        pop = 1'b0;
  logic [31:0] pop_data;
  logic        flush = 1'b0;
  logic [31:0] status;
  logic        resp_ready;
  logic        underrun;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rx_pack_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_byte_i(push_byte),
    .full_o(full), .pop_i(pop), .pop_data_o(pop_data), .flush_i(flush),
    .status_o(status), .resp_ready_o(resp_ready), .underrun_o(underrun)
  );

  function automatic logic [31:0] exp_stat(int c);
    logic [31:0] s = '0;
    s[0] = (c > 0); s[1] = (c >= 16); s[2] = (c >= 32); s[3] = (c >= 64);
    s[10:4] = 7'(c); s[11] = (c == 0);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_push(logic [7:0] b);
    push_valid = 1'b1; push_byte = b;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic do_pop(output logic [31:0] d);
    pop = 1'b1;
    #1 d = pop_data;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0000_0800);
    chk("R1 flags", {resp_ready, underrun, full}, 3'b000);
  endtask

  task automatic t_word_and_partial();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) do_push(8'(8'h11 * i));
    chk("R2 count5", status, exp_stat(5));
    chk("R3 ready", resp_ready, 1'b1);
    do_pop(d);
    chk("R6 little-endian word", d, 32'h4433_2211);
    chk("R6 removes four", status, exp_stat(1));
    do_pop(d);
    chk("R7 partial word", d, 32'h0000_0055);
    chk("R7 removes one", status, exp_stat(0));
    chk("R3 not ready", resp_ready, 1'b0);
    for (int i = 0; i < 3; i++) do_push(8'(8'hA0 + i));
    do_pop(d);
    chk("R7 three bytes", d, 32'h00A2_A1A0);
    chk("R5 empty after partial", status, exp_stat(0));
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    do_pop(d);
    chk("R8 empty pop data", d, 32'h0);
    chk("R8 flag set", underrun, 1'b1);
    chk("R8 stays empty", status, exp_stat(0));
    do_push(8'h3C);
    chk("R8 sticky", underrun, 1'b1);
    do_flush();
    chk("R9 flush clears underrun", underrun, 1'b0);
    chk("R9 flush empties", status, exp_stat(0));
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    for (int i = 0; i < 64; i++) begin
      do_push(8'(i));
      if (i == 14 || i == 15 || i == 30 || i == 31 || i == 62)
        chk("R4 threshold", status, exp_stat(i + 1));
    end
    chk("R4 all thresholds", status, exp_stat(64));
    chk("R10 full", full, 1'b1);
    do_push(8'hEE);
    chk("R10 dropped push", status, exp_stat(64));
    for (int w = 0; w < 16; w++) begin
      do_pop(d);
      chk("R10 order kept", d, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    end
    chk("R10 drained", {full, status}, {1'b0, exp_stat(0)});
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) do_push(8'(8'h70 + i));
    chk("R2 count10", status, exp_stat(10));
    push_valid = 1'b1; push_byte = 8'h99;
    do_flush();
    push_valid = 1'b0;
    chk("R9 flush wins over push", status, exp_stat(0));
    do_push(8'hA5);
    do_pop(d);
    chk("R9 queue usable after flush", d, 32'h0000_00A5);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    for (int i = 1; i <= 3; i++) do_push(8'(i));
    push_valid = 1'b1; push_byte = 8'h04;
    do_pop(d);
    push_valid = 1'b0;
    chk("R11 pop sees old bytes", d, 32'h0003_0201);
    chk("R11 net count", status, exp_stat(1));
    do_pop(d);
    chk("R11 new byte queued", d, 32'h0000_0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_and_partial();
    t_underrun();
    t_thresholds();
    t_flush();
    t_simul();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule